// File: doc/BRIEF.md
# FizzBuzz Line String Generator

This block walks through the integers 1 to 100. For the current value it presents one eight-character text line. Each character is a 4-bit code, and the eight codes are packed into a single 32-bit word. The line holds "Fizz" when the value divides by three, "Buzz" when it divides by five, and "FizzBuzz" when it divides by fifteen. Any other value appears as its decimal digits. The block has no divider. The value is held as a chain of BCD digit counters, and divisibility comes from two residue counters, one modulo 3 and one modulo 5, which step together with the value.

A raster timing generator drives the block with a per-line strobe and the current line number. The value advances only on the strobe for the last pixel row of an eight-row character cell. This keeps every text row stable while a full cell is drawn. The output word is a plain level that a glyph renderer reads whenever it needs it. It has no valid/ready handshake, because there is no transfer to throttle: the word is simply the current state, and a consumer that lags behind misses nothing.

Top module: `fzb_line_gen`

## Requirements
- R1: After reset the line shows the value 1, which is the word 32'h1FFF_FFFF.
- R2: Each qualifying step moves the shown value to the next integer, starting from 1.
- R3: The value is kept as BCD digits, each in the range 0 to 9, and the digit carries follow decimal counting.
- R4: A value that divides by 3 but not by 5 produces "Fizz", the word 32'hBCEE_FFFF (F=11, i=12, z=14, then four spaces).
- R5: A value that divides by 5 but not by 3 produces "Buzz", the word 32'hADEE_FFFF (B=10, u=13, z=14, then four spaces).
- R6: A value that divides by 15 produces "FizzBuzz", the word 32'hBCEE_ADEE.
- R7: Any other value produces its decimal digits, coded 0 to 9. The digits are left-aligned with the first character in bits 31:28, leading zeros are dropped, and the remaining positions are filled with code 15 (space).
- R8: The value steps only in a cycle where `line_strobe` is high and the low three bits of `line_num` are all ones. In every other cycle the word is unchanged.
- R9: A step taken while the value is 100 returns the value to 1, and both residues restart at the values that belong to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_strobe | input | 1 | One-cycle pulse at the start of each raster line |
| line_num | input | 10 | Current raster line number |
| line_word | output | 32 | Eight 4-bit character codes, first character in the top nibble |

## Verification
A residue counter that drifts out of phase puts "Fizz" or "Buzz" on the wrong values. Because 3 and 5 are small, such a fault reaches the port within five steps. A broken BCD carry shows up as a wrong digit pair at the next decade boundary, and a faulty wrap shows up on the step after 100. A wrong step qualifier changes the word in the middle of a cell. The bench therefore compares the word after every raster line, including lines that must leave it alone, and runs through the sequence twice so that every value and the wrap are each seen at least twice.

// File: rtl/fzb_pkg.sv
package fzb_pkg;
  localparam int CODE_W = 4;
  localparam int CHARS  = 8;
  localparam int WORD_W = CODE_W * CHARS;

  typedef logic [CODE_W-1:0] code_t;

  // digits use codes 0..9 directly
  localparam code_t C_B     = 4'd10;
  localparam code_t C_F     = 4'd11;
  localparam code_t C_I     = 4'd12;
  localparam code_t C_U     = 4'd13;
  localparam code_t C_Z     = 4'd14;
  localparam code_t C_SPACE = 4'd15;

  localparam logic [4*CODE_W-1:0] FIZZ_W = {C_F, C_I, C_Z, C_Z};
  localparam logic [4*CODE_W-1:0] BUZZ_W = {C_B, C_U, C_Z, C_Z};
endpackage

// File: rtl/fzb_bcd_counter.sv
module fzb_bcd_counter #(
  parameter int DIGITS = 3,
  parameter int INIT   = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step,
  input  logic                    restart,
  output logic [DIGITS-1:0][3:0]  digits
);
  logic [DIGITS:0] carry;
  assign carry[0] = step;

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    localparam logic [3:0] INIT_D = 4'((INIT / (10 ** i)) % 10);

    assign carry[i+1] = carry[i] && (digits[i] == 4'd9);

    always_ff @(posedge clk) begin
      if (!rst_n || restart)
        digits[i] <= INIT_D;
      else if (carry[i])
        digits[i] <= (digits[i] == 4'd9) ? 4'd0 : digits[i] + 4'd1;
    end

    AST_BCD_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      digits[i] <= 4'd9); // R3
  end
endmodule

// File: rtl/fzb_residue.sv
module fzb_residue #(
  parameter int MODULUS = 3,
  parameter int INIT    = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       step,
  input  logic                       restart,
  output logic [$clog2(MODULUS)-1:0] count
);
  localparam int W = $clog2(MODULUS);
  localparam logic [W-1:0] TOP    = W'(MODULUS - 1);
  localparam logic [W-1:0] INIT_R = W'(INIT % MODULUS);

  always_ff @(posedge clk) begin
    if (!rst_n || restart)
      count <= INIT_R;
    else if (step)
      count <= (count == TOP) ? '0 : count + 1'b1;
  end

  AST_RESIDUE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    count <= TOP); // R4
endmodule

// File: rtl/fzb_line_format.sv
module fzb_line_format
  import fzb_pkg::*;
#(
  parameter int DIGITS = 3
) (
  input  logic [DIGITS-1:0][3:0] digits,
  input  logic                   fizz,
  input  logic                   buzz,
  output logic [WORD_W-1:0]      word
);
  logic [CHARS-1:0][CODE_W-1:0] num_chars;
  int                           ndig;

  always_comb begin
    ndig = 1;
    for (int i = 1; i < DIGITS; i++)
      if (digits[i] != 4'd0) ndig = i + 1;
    for (int k = 0; k < CHARS; k++) begin
      if (k < ndig)
        num_chars[CHARS-1-k] = digits[ndig-1-k];
      else
        num_chars[CHARS-1-k] = C_SPACE;
    end
  end

  always_comb begin
    word = {WORD_W{1'b1}};
    if (fizz && buzz)
      word[WORD_W-1 -: 8*CODE_W] = {FIZZ_W, BUZZ_W};
    else if (fizz)
      word[WORD_W-1 -: 4*CODE_W] = FIZZ_W;
    else if (buzz)
      word[WORD_W-1 -: 4*CODE_W] = BUZZ_W;
    else
      word = num_chars;
  end
endmodule

// File: rtl/fzb_line_gen.sv
module fzb_line_gen
  import fzb_pkg::*;
#(
  parameter int LINE_W     = 10,
  parameter int CELL_LOG2  = 3,
  parameter int DIGITS     = 3,
  parameter int LAST_VALUE = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_strobe,
  input  logic [LINE_W-1:0] line_num,
  output logic [WORD_W-1:0] line_word
);
  logic [DIGITS-1:0][3:0] digits;
  logic [DIGITS-1:0]      last_match;
  logic                   step, at_last, restart;
  logic [1:0]             res3;
  logic [2:0]             res5;

  assign step    = line_strobe && (&line_num[CELL_LOG2-1:0]);
  assign at_last = &last_match;
  assign restart = step && at_last;

  for (genvar i = 0; i < DIGITS; i++) begin : g_last
    assign last_match[i] = (digits[i] == 4'((LAST_VALUE / (10 ** i)) % 10));
  end

  fzb_bcd_counter #(.DIGITS(DIGITS), .INIT(1)) u_bcd (
    .clk(clk), .rst_n(rst_n), .step(step), .restart(restart), .digits(digits));

  fzb_residue #(.MODULUS(3), .INIT(1)) u_mod3 (
    .clk(clk), .rst_n(rst_n), .step(step), .restart(restart), .count(res3));

  fzb_residue #(.MODULUS(5), .INIT(1)) u_mod5 (
    .clk(clk), .rst_n(rst_n), .step(step), .restart(restart), .count(res5));

  fzb_line_format #(.DIGITS(DIGITS)) u_fmt (
    .digits(digits), .fizz(res3 == 2'd0), .buzz(res5 == 3'd0), .word(line_word));

  AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(line_word)); // R8

  AST_WRAP_TO_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (line_word[WORD_W-1 -: 2*CODE_W] == {4'd1, C_SPACE})); // R9

  AST_FIFTEEN_AFTER_FOURTEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (step && digits[1] == 4'd1 && digits[0] == 4'd4 && digits[2] == 4'd0)
      |=> (line_word == {FIZZ_W, BUZZ_W})); // R6
endmodule

// File: tb/fzb_line_gen_test.sv
module fzb_line_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_strobe = 1'b0;
  logic [9:0]  line_num = '0;
  logic [31:0] line_word;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fzb_line_gen uut (
    .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe),
    .line_num(line_num), .line_word(line_word));

  function automatic logic [31:0] expect_word(int n);
    logic [31:0] w;
    int nd;
    int d [3];
    w = 32'hFFFF_FFFF;
    if (n % 15 == 0)      w = 32'hBCEE_ADEE;
    else if (n % 3 == 0)  w = 32'hBCEE_FFFF;
    else if (n % 5 == 0)  w = 32'hADEE_FFFF;
    else begin
      d[0] = n / 100; d[1] = (n / 10) % 10; d[2] = n % 10;
      nd = (n >= 100) ? 3 : (n >= 10) ? 2 : 1;
      for (int k = 0; k < nd; k++)
        w[31 - 4*k -: 4] = 4'(d[3 - nd + k]);
    end
    return w;
  endfunction

  function automatic string tag_of(int n);
    if (n % 15 == 0) return "R6";
    if (n % 3 == 0)  return "R4";
    if (n % 5 == 0)  return "R5";
    return "R7";
  endfunction

  task automatic check(string req, logic [31:0] exp);
    checks++;
    if (line_word !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, line_word, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // one cycle of stimulus, sampled at the following falling edge
  task automatic drive(logic s, int y);
    @(negedge clk);
    line_strobe = s;
    line_num = 10'(y);
    @(negedge clk);
    line_strobe = 1'b0;
  endtask

  initial begin
    int n;
    int y;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 32'h1FFF_FFFF);

    // non-qualifying cycles must leave the word alone
    for (int k = 0; k < 7; k++) begin
      drive(1'b1, k);
      check("R8", 32'h1FFF_FFFF);
    end
    drive(1'b0, 7);
    check("R8", 32'h1FFF_FFFF);
    drive(1'b0, 1023);
    check("R8", 32'h1FFF_FFFF);

    n = 1;
    y = 0;
    for (int it = 0; it < 8 * 215; it++) begin
      drive(1'b1, y);
      if ((y % 8) == 7) begin
        if (n == 100) begin
          n = 1;
          check("R9", expect_word(n));
        end else begin
          n = n + 1;
          check((n % 10 == 0) ? "R3" : "R2", expect_word(n));
        end
      end
      check(tag_of(n), expect_word(n));
      if ((it % 5) == 0) begin
        drive(1'b0, 7);
        check("R8", expect_word(n));
      end
      y = (y + 1) % 1024;
    end

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 32'h1FFF_FFFF);
    done = 1;
    finish_run();
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      finish_run();
    end
  end
endmodule